// File: doc/BRIEF.md
# Partial-Register Rename Merge Tracker

This block sits in the rename stage of an out-of-order core. It tracks sixteen 64-bit architectural registers, and each register has a high-byte part (bits 15:8) that can be renamed on its own. For each register the block holds a producer tag for the full part, a producer tag for the high-byte part, and a dirty flag. The dirty flag is set while those two parts live under different tags. Micro-ops arrive in program order, one per cycle. Each carries an optional source register with a read size and an optional destination register with a write size. The high-byte selector applies only to the byte size.

For each micro-op accepted, the block produces one registered output record. The record holds the producer tags the micro-op depends on and the new tag given to its result. Tags come from a 6-bit counter that wraps.

When a read of 16 bits or more hits a dirty register, the parts must be joined first. The block holds the micro-op back for one cycle with its ready signal and emits a two-input merge micro-op on its own in the output slot. The reading micro-op follows in the next cycle and depends only on the merged tag.

Top module: `prmt_merge_tracker`

## Requirements
- R1: After reset every register is clean, its full-part tag equals its register index, `in_ready` is 1, `out_valid` is 0, and the first tag allocated is 16.
- R2: Each allocation (a micro-op with a destination, or a merge) takes the current counter value as its destination tag. The next allocation gets that value plus one, modulo 64. `out_dst_vld` is 1 exactly when a tag was allocated.
- R3: A write of size code 2 (32-bit) or 3 (64-bit) gets a new full-part tag, leaves the register clean, and reports no dependency on the old value (`out_src_b_vld` = 0).
- R4: A write of size code 1 (16-bit), or of size code 0 with the high-byte selector at 0 (low byte), reports the register's previous full-part tag on source B. It gets a new full-part tag and leaves the dirty flag unchanged.
- R5: A write of size code 0 with the high-byte selector at 1 gets a new high-byte tag, sets the dirty flag, leaves the full-part tag unchanged, and reports no source B dependency.
- R6: When a valid micro-op reads a dirty register with size code 1, 2 or 3, `in_ready` is 0 in that cycle. In the next cycle the output is a merge (`out_merge` = 1) with source A = full-part tag, source B = high-byte tag and a newly allocated destination tag.
- R7: A merge occupies its output cycle alone. Once the merge has been emitted the register is clean with the merge's tag as its full-part tag, so the held micro-op is accepted in the following cycle and emitted one cycle later as a non-merge record whose source A is the merged tag.
- R8: Byte reads never merge. A high-byte read of a dirty register uses the high-byte tag. A high-byte read of a clean register, and any low-byte read, uses the full-part tag.
- R9: In a cycle with `in_valid` = 0 nothing changes and the next output has `out_valid` = 0, whatever the other input fields hold.
- R10: When a micro-op reads and writes the same register, the source tag is the value from before the micro-op's own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A micro-op is presented |
| in_ready | output | 1 | The presented micro-op is accepted this cycle |
| in_src_en | input | 1 | The micro-op reads a register |
| in_src_reg | input | 4 | Source register index |
| in_src_size | input | 2 | Read size code: 0 = byte, 1 = 16, 2 = 32, 3 = 64 bits |
| in_src_hi | input | 1 | With size code 0, selects the high byte |
| in_dst_en | input | 1 | The micro-op writes a register |
| in_dst_reg | input | 4 | Destination register index |
| in_dst_size | input | 2 | Write size code, same encoding as the read size |
| in_dst_hi | input | 1 | With size code 0, selects the high byte |
| out_valid | output | 1 | Output record is valid |
| out_merge | output | 1 | Output record is an inserted merge |
| out_src_a_vld | output | 1 | Source A tag is used |
| out_src_a | output | 6 | Source A producer tag |
| out_src_b_vld | output | 1 | Source B tag is used |
| out_src_b | output | 6 | Source B producer tag |
| out_dst_vld | output | 1 | A destination tag was allocated |
| out_dst | output | 6 | Allocated destination tag |

## Verification
The assertions check the handshake every cycle:
- a stall is always followed by a merge record;
- a merge always names two sources and a destination;
- a held micro-op is accepted in the cycle after its merge;
- byte reads never stall;
- wide writes never report a dependency;
- tags step by one per allocation.

Only the bench's scenarios can show that the tag values themselves are right. That covers which tag a byte read picks from a dirty register, that a low-byte write keeps the register dirty, that tags wrap past 63, and that a same-register read sees the value from before the write. The bench shows these by comparing every output field with an independent model over directed and random sequences.

// File: rtl/prmt_pkg.sv
package prmt_pkg;
    localparam int NREGS  = 16;
    localparam int TAG_W  = 6;
    localparam int RIDX_W = $clog2(NREGS);
    localparam int SZ_W   = 2;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [SZ_W-1:0] {
        SZ_B8  = 2'd0,
        SZ_W16 = 2'd1,
        SZ_D32 = 2'd2,
        SZ_Q64 = 2'd3
    } opsz_e;

    typedef struct packed {
        tag_t full;
        tag_t hi;
        logic dirty;
    } ent_t;

    typedef struct packed {
        logic valid;
        logic merge;
        logic a_vld;
        tag_t a;
        logic b_vld;
        tag_t b;
        logic d_vld;
        tag_t d;
    } uop_out_t;
endpackage

// File: rtl/prmt_table.sv
module prmt_table
    import prmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ridx_t rd_a_idx,
    output ent_t  rd_a,
    input  ridx_t rd_b_idx,
    output ent_t  rd_b,
    input  logic  we,
    input  ridx_t wr_idx,
    input  ent_t  wr_ent
);
    ent_t ent_q [NREGS];
    ent_t ent_d [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            ent_d[i] = ent_q[i];
            if (we && (wr_idx == ridx_t'(i))) begin
                ent_d[i] = wr_ent;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                ent_q[i] <= '{full: tag_t'(i), hi: tag_t'(i), dirty: 1'b0};
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign rd_a = ent_q[rd_a_idx];
    assign rd_b = ent_q[rd_b_idx];
endmodule

// File: rtl/prmt_tag_alloc.sv
module prmt_tag_alloc
    import prmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alloc,
    output tag_t tag
);
    tag_t cnt_q;
    tag_t cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (alloc) begin
            cnt_d = cnt_q + tag_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= tag_t'(NREGS);
        else        cnt_q <= cnt_d;
    end

    assign tag = cnt_q;

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (tag == tag_t'($past(tag) + tag_t'(1)))); // R2
    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc |=> $stable(tag)); // R2
endmodule

// File: rtl/prmt_ctrl.sv
module prmt_ctrl
    import prmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_src_en,
    input  ridx_t           in_src_reg,
    input  logic [SZ_W-1:0] in_src_size,
    input  logic            in_src_hi,
    input  logic            in_dst_en,
    input  ridx_t           in_dst_reg,
    input  logic [SZ_W-1:0] in_dst_size,
    input  logic            in_dst_hi,
    input  ent_t            src_ent,
    input  ent_t            dst_ent,
    input  tag_t            new_tag,
    output logic            in_ready,
    output logic            we,
    output ridx_t           wr_idx,
    output ent_t            wr_ent,
    output logic            alloc,
    output uop_out_t        nxt
);
    logic need_merge;
    logic dst_wide;
    logic dst_hi_byte;

    always_comb begin
        need_merge  = in_valid && in_src_en && (in_src_size != SZ_B8) && src_ent.dirty;
        dst_wide    = (in_dst_size == SZ_D32) || (in_dst_size == SZ_Q64);
        dst_hi_byte = (in_dst_size == SZ_B8) && in_dst_hi;
        nxt         = '0;
        we          = 1'b0;
        wr_idx      = in_src_reg;
        wr_ent      = src_ent;
        alloc       = 1'b0;
        in_ready    = 1'b1;
        if (need_merge) begin
            in_ready     = 1'b0;
            nxt.valid    = 1'b1;
            nxt.merge    = 1'b1;
            nxt.a_vld    = 1'b1;
            nxt.a        = src_ent.full;
            nxt.b_vld    = 1'b1;
            nxt.b        = src_ent.hi;
            nxt.d_vld    = 1'b1;
            nxt.d        = new_tag;
            alloc        = 1'b1;
            we           = 1'b1;
            wr_ent.full  = new_tag;
            wr_ent.dirty = 1'b0;
        end else if (in_valid) begin
            nxt.valid = 1'b1;
            if (in_src_en) begin
                nxt.a_vld = 1'b1;
                nxt.a     = ((in_src_size == SZ_B8) && in_src_hi && src_ent.dirty)
                            ? src_ent.hi : src_ent.full;
            end
            if (in_dst_en) begin
                alloc     = 1'b1;
                nxt.d_vld = 1'b1;
                nxt.d     = new_tag;
                we        = 1'b1;
                wr_idx    = in_dst_reg;
                wr_ent    = dst_ent;
                if (dst_wide) begin
                    wr_ent.full  = new_tag;
                    wr_ent.dirty = 1'b0;
                end else if (dst_hi_byte) begin
                    wr_ent.hi    = new_tag;
                    wr_ent.dirty = 1'b1;
                end else begin
                    nxt.b_vld   = 1'b1;
                    nxt.b       = dst_ent.full;
                    wr_ent.full = new_tag;
                end
            end
        end
    end

    AST_BYTE_READ_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_src_en && (in_src_size == SZ_B8)) |-> in_ready); // R8
    AST_WIDE_WRITE_NO_DEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dst_en && (in_dst_size[1] == 1'b1)) |-> !nxt.b_vld); // R3
endmodule

// File: rtl/prmt_merge_tracker.sv
module prmt_merge_tracker
    import prmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_src_en,
    input  logic [RIDX_W-1:0] in_src_reg,
    input  logic [SZ_W-1:0]   in_src_size,
    input  logic              in_src_hi,
    input  logic              in_dst_en,
    input  logic [RIDX_W-1:0] in_dst_reg,
    input  logic [SZ_W-1:0]   in_dst_size,
    input  logic              in_dst_hi,
    output logic              out_valid,
    output logic              out_merge,
    output logic              out_src_a_vld,
    output logic [TAG_W-1:0]  out_src_a,
    output logic              out_src_b_vld,
    output logic [TAG_W-1:0]  out_src_b,
    output logic              out_dst_vld,
    output logic [TAG_W-1:0]  out_dst
);
    ent_t     src_ent;
    ent_t     dst_ent;
    ent_t     wr_ent;
    ridx_t    wr_idx;
    logic     we;
    logic     alloc;
    tag_t     new_tag;
    uop_out_t ctrl_out;
    uop_out_t out_d;
    uop_out_t out_q;

    prmt_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (in_src_reg),
        .rd_a     (src_ent),
        .rd_b_idx (in_dst_reg),
        .rd_b     (dst_ent),
        .we       (we),
        .wr_idx   (wr_idx),
        .wr_ent   (wr_ent)
    );

    prmt_tag_alloc u_alloc (
        .clk   (clk),
        .rst_n (rst_n),
        .alloc (alloc),
        .tag   (new_tag)
    );

    prmt_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_src_en   (in_src_en),
        .in_src_reg  (in_src_reg),
        .in_src_size (in_src_size),
        .in_src_hi   (in_src_hi),
        .in_dst_en   (in_dst_en),
        .in_dst_reg  (in_dst_reg),
        .in_dst_size (in_dst_size),
        .in_dst_hi   (in_dst_hi),
        .src_ent     (src_ent),
        .dst_ent     (dst_ent),
        .new_tag     (new_tag),
        .in_ready    (in_ready),
        .we          (we),
        .wr_idx      (wr_idx),
        .wr_ent      (wr_ent),
        .alloc       (alloc),
        .nxt         (ctrl_out)
    );

    always_comb begin
        out_d = ctrl_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid     = out_q.valid;
    assign out_merge     = out_q.merge;
    assign out_src_a_vld = out_q.a_vld;
    assign out_src_a     = out_q.a;
    assign out_src_b_vld = out_q.b_vld;
    assign out_src_b     = out_q.b;
    assign out_dst_vld   = out_q.d_vld;
    assign out_dst       = out_q.d;

    AST_STALL_GIVES_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (out_valid && out_merge)); // R6
    AST_MERGE_TWO_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_merge) |-> (out_src_a_vld && out_src_b_vld && out_dst_vld)); // R6
    AST_HELD_OP_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && !in_ready) && in_valid && (in_src_reg == $past(in_src_reg))
         && (in_src_size == $past(in_src_size))) |-> in_ready); // R7
    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
endmodule

// File: tb/tb_prmt_merge_tracker.sv
module tb_prmt_merge_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_ready;
    logic       in_src_en = 1'b0, in_src_hi = 1'b0, in_dst_en = 1'b0, in_dst_hi = 1'b0;
    logic [3:0] in_src_reg = '0, in_dst_reg = '0;
    logic [1:0] in_src_size = '0, in_dst_size = '0;
    logic       out_valid, out_merge, out_src_a_vld, out_src_b_vld, out_dst_vld;
    logic [5:0] out_src_a, out_src_b, out_dst;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prmt_merge_tracker dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src_en(in_src_en), .in_src_reg(in_src_reg), .in_src_size(in_src_size),
        .in_src_hi(in_src_hi), .in_dst_en(in_dst_en), .in_dst_reg(in_dst_reg),
        .in_dst_size(in_dst_size), .in_dst_hi(in_dst_hi), .out_valid(out_valid),
        .out_merge(out_merge), .out_src_a_vld(out_src_a_vld), .out_src_a(out_src_a),
        .out_src_b_vld(out_src_b_vld), .out_src_b(out_src_b),
        .out_dst_vld(out_dst_vld), .out_dst(out_dst)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int m_full [NR];
    int m_hi [NR];
    bit m_dirty [NR];
    int m_tag;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_src(int r, int sz, bit hi);
        if (sz == 0 && hi && m_dirty[r]) return m_hi[r];
        return m_full[r];
    endfunction

    function automatic string dst_req(int sz, bit hi);
        if (sz >= 2) return "R3";
        if (sz == 0 && hi) return "R5";
        return "R4";
    endfunction

    task automatic do_op(string lbl, bit se, int sr, int ssz, bit shi,
                         bit de, int dr, int dsz, bit dhi);
        int ea;
        int eb;
        bit ebv;
        string rq;
        in_valid = 1'b1;
        in_src_en = se; in_src_reg = 4'(sr); in_src_size = 2'(ssz); in_src_hi = shi;
        in_dst_en = de; in_dst_reg = 4'(dr); in_dst_size = 2'(dsz); in_dst_hi = dhi;
        #1;
        if (se && ssz != 0 && m_dirty[sr]) begin
            chk("R6 ready low on wide dirty read", in_ready, 0);
            @(negedge clk);
            chk("R6 merge valid", out_valid, 1);
            chk("R6 merge flag", out_merge, 1);
            chk("R6 merge src a", out_src_a, m_full[sr]);
            chk("R6 merge src b valid", out_src_b_vld, 1);
            chk("R6 merge src b", out_src_b, m_hi[sr]);
            chk("R2 merge dst", out_dst, m_tag);
            m_full[sr] = m_tag;
            m_dirty[sr] = 1'b0;
            m_tag = (m_tag + 1) % 64;
            #1;
            chk("R7 ready after merge", in_ready, 1);
        end else begin
            chk("R8 ready without merge", in_ready, 1);
        end
        ea  = se ? exp_src(sr, ssz, shi) : 0;
        ebv = de && dsz < 2 && !(dsz == 0 && dhi);
        eb  = ebv ? m_full[dr] : 0;
        rq  = dst_req(dsz, dhi);
        @(negedge clk);
        chk("R7 op valid", out_valid, 1);
        chk("R7 op not merge", out_merge, 0);
        chk({lbl, " src a valid"}, out_src_a_vld, se);
        chk({lbl, " src a tag"}, out_src_a, ea);
        chk({rq, " src b valid"}, out_src_b_vld, ebv);
        chk({rq, " src b tag"}, out_src_b, eb);
        chk("R2 dst valid", out_dst_vld, de);
        chk("R2 dst tag", out_dst, de ? m_tag : 0);
        if (de) begin
            if (dsz >= 2) begin
                m_full[dr] = m_tag; m_dirty[dr] = 1'b0;
            end else if (dsz == 0 && dhi) begin
                m_hi[dr] = m_tag; m_dirty[dr] = 1'b1;
            end else begin
                m_full[dr] = m_tag;
            end
            m_tag = (m_tag + 1) % 64;
        end
        in_valid = 1'b0;
    endtask

    task automatic idle_garbage();
        in_valid = 1'b0;
        in_src_en = 1'b1; in_src_size = 2'd3; in_src_reg = 4'd1;
        in_dst_en = 1'b1; in_dst_size = 2'd0; in_dst_hi = 1'b1; in_dst_reg = 4'd2;
        @(negedge clk);
        chk("R9 idle gives no output", out_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0bad5eed));
        for (int i = 0; i < NR; i++) begin
            m_full[i] = i; m_hi[i] = i; m_dirty[i] = 1'b0;
        end
        m_tag = 16;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 out_valid after reset", out_valid, 0);
        chk("R1 ready after reset", in_ready, 1);
        for (int r = 0; r < NR; r++) do_op("R1", 1, r, 3, 0, 0, 0, 0, 0);
        do_op("R1", 0, 0, 0, 0, 1, 7, 3, 0);            // R1 first tag is 16
        // hi write, then a wide read merges
        do_op("R8", 0, 0, 0, 0, 1, 1, 0, 1);            // R5
        do_op("R8", 1, 1, 3, 0, 1, 2, 3, 0);            // R6 R7
        // byte reads of a dirty register
        do_op("R8", 0, 0, 0, 0, 1, 3, 0, 1);
        do_op("R8", 1, 3, 0, 1, 0, 0, 0, 0);            // hi byte tag
        do_op("R8", 1, 3, 0, 0, 0, 0, 0, 0);            // low byte, full tag
        do_op("R8", 0, 0, 0, 0, 1, 3, 1, 0);            // R4 keeps dirty
        do_op("R8", 1, 3, 2, 0, 0, 0, 0, 0);            // still merges
        do_op("R8", 1, 3, 0, 1, 0, 0, 0, 0);            // clean hi read uses full
        // wide write clears dirty
        do_op("R8", 0, 0, 0, 0, 1, 4, 0, 1);
        do_op("R8", 0, 0, 0, 0, 1, 4, 2, 0);            // R3
        do_op("R8", 1, 4, 3, 0, 0, 0, 0, 0);
        // same register read and written
        do_op("R10", 1, 5, 3, 0, 1, 5, 3, 0);
        do_op("R10", 0, 0, 0, 0, 1, 6, 0, 1);
        do_op("R10", 1, 6, 2, 0, 1, 6, 1, 0);
        repeat (3) idle_garbage();
        do_op("R9", 1, 1, 3, 0, 0, 0, 0, 0);            // R9 idle fields changed nothing
        do_op("R9", 1, 2, 3, 0, 0, 0, 0, 0);
        for (int n = 0; n < 400; n++) begin
            int sr;
            int dr;
            sr = ($urandom % 2 == 0) ? int'($urandom % 4) : int'($urandom % NR);
            dr = ($urandom % 2 == 0) ? int'($urandom % 4) : int'($urandom % NR);
            if ($urandom % 8 == 0) idle_garbage();
            do_op("R8", bit'($urandom % 4 != 0), sr, int'($urandom % 4), bit'($urandom % 2),
                  bit'($urandom % 5 != 0), dr, int'($urandom % 4), bit'($urandom % 2));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule